// File: doc/BRIEF.md
# Dual-Mode FIFO with Retransmit

This block is a single-clock FIFO with an internal storage array of parameterized depth and an 18-bit data path. While master reset is held low, the block samples a mode input on each clock edge and keeps the last value it saw. That value selects one of two flag and read behaviours:

- **Standard mode.** Every word must be requested with a read-enable pulse. The read-side flag means "empty" and the write-side flag means "full".
- **Fall-through mode.** The oldest word is presented on the output without any request. The read-side flag means "output ready" and the write-side flag means "input ready".

Both flags are active low.

Two asynchronous resets are provided. Master reset clears everything and captures the mode. Partial reset clears the pointers, the flags and the output register, and leaves the mode unchanged.

A retransmit request rewinds the read pointer to location zero so that stored data can be read again. The read-side flag shows that the rewind is in progress and shows when it is finished.

Top module: `dual_mode_fifo`

## Requirements
- R1: Master reset (`mrst_n` low) acts asynchronously. It clears `rd_data` to zero and returns both pointers to location 0. The mode is taken from `mode_sel` at clock edges while `mrst_n` is low: 0 selects standard mode and 1 selects fall-through mode.
- R2: Immediately after any reset, the flags depend on the mode. In standard mode, `rd_flag_n` (empty) = 0 and `wr_flag_n` (full) = 1. In fall-through mode, `rd_flag_n` (output-ready) = 1 and `wr_flag_n` (input-ready) = 0.
- R3: Partial reset (`prst_n` low) acts asynchronously. It clears `rd_data`, the pointers and the flags in the same way as master reset, and the selected mode is kept.
- R4: A write happens when `wr_en_n` is 0 at a clock edge and the FIFO is not full. The word goes to the next location in sequence. When `wr_en_n` is 1, nothing is stored and the write pointer holds.
- R5: In standard mode, a word becomes readable on the second edge after the edge that wrote it, and `rd_flag_n` rises at that point. Each edge with `rd_en_n` = 0 and a readable word updates `rd_data` with the oldest word. Words come out in write order.
- R6: In fall-through mode, a word written into an empty FIFO appears on `rd_data` after the third edge following its write edge, and `rd_flag_n` goes to 0 at the same time, with no read enable needed. The word stays on the output until an edge with `rd_en_n` = 0 replaces it with the next word, or drops `rd_flag_n` to 1 if no word is left.
- R7: After the edge that stores the DEPTH-th word, the write flag shows full: `wr_flag_n` = 0 in standard mode, 1 in fall-through mode. Further writes are dropped until a word leaves the FIFO.
- R8: A read request is ignored, and `rd_data` is left unchanged, when the FIFO is empty in standard mode or `rd_flag_n` = 1 in fall-through mode.
- R9: Retransmit setup begins on an edge where `rewind_n` = 0 and both `wr_en_n` and `rd_en_n` are 1. Setup moves the read pointer to location 0. It holds `rd_flag_n` at 0 in standard mode, or at 1 in fall-through mode, for as long as `rewind_n` stays low.
- R10: Setup finishes on the first edge with `rewind_n` = 1. The occupancy becomes the number of locations from 0 up to the write pointer, or the whole array if the write pointer has wrapped since reset.
  - In standard mode, `rd_flag_n` then rises if any data is stored.
  - In fall-through mode, `rd_flag_n` falls with the word from location 0 already on `rd_data`.
  - Later reads continue from location 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the write side and the read side |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low; the mode is kept |
| mode_sel | input | 1 | Mode choice sampled during master reset (0 standard, 1 fall-through) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 18 | Output data register |
| rewind_n | input | 1 | Retransmit request, active low |
| rd_flag_n | output | 1 | Empty flag (standard mode) or output-ready flag (fall-through mode) |
| wr_flag_n | output | 1 | Full flag (standard mode) or input-ready flag (fall-through mode) |

## Verification
The retransmit properties assume that a rewind request arrives only with both enables inactive. The stimulus keeps `wr_en_n` and `rd_en_n` high on every edge where `rewind_n` is low. The hold properties on `rd_data` assume that a partial reset spans at least one clock edge, so the bench holds `prst_n` low across an edge before releasing it. The mode is assumed to change only under master reset, and the bench changes `mode_sel` only while `mrst_n` is low.

// File: rtl/dmf_pkg.sv
// Shared types for the dual-mode FIFO.
// Assumes: the data path width is fixed for every instance in the chip.
package dmf_pkg;
    localparam int unsigned DATA_W = 18;

    // Output behaviour chosen during master reset.
    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_FT  = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dmf_ram.sv
// Storage array: one synchronous write port and one combinational read port.
// Assumes: addresses are always below DEPTH; the contents are not reset.
module dmf_ram #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_ctrl.sv
// Pointer, occupancy and retransmit control for the dual-mode FIFO.
// occ counts the words held in the array. vis counts the words that have
// finished the two-edge write latency and may be popped.
// Assumes: rst_n is the combined asynchronous reset, and the mode is stable
// outside master reset.
module dmf_ctrl
    import dmf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_mode_e    mode,
    input  logic          wr_en_n,
    input  logic          rd_en_n,
    input  logic          rewind_n,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          pop,
    output logic          out_valid,
    output logic          vis_nz,
    output logic          full,
    output logic          rt_busy,
    output logic [CW-1:0] occ
);
    logic [AW-1:0] wptr_q, rptr_q;
    logic          wrap_q;
    logic [CW-1:0] occ_q, vis_q;
    logic [1:0]    wpipe_q;
    logic          busy_q, oval_q;

    logic          do_wr, rt_start, rt_done, std_rd, ft_take, ft_load;
    logic [CW-1:0] rewind_occ;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        step = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decode this cycle's write, pop and retransmit events.
    always_comb begin
        full       = (occ_q == CW'(DEPTH));
        do_wr      = !wr_en_n && !full;
        rt_start   = !rewind_n && !busy_q && wr_en_n && rd_en_n;
        rt_done    = busy_q && rewind_n;
        std_rd     = (mode == MODE_STD) && !rd_en_n && (vis_q != '0) && !busy_q;
        ft_take    = (mode == MODE_FT) && oval_q && !rd_en_n && !busy_q;
        ft_load    = (mode == MODE_FT) && (vis_q != '0) &&
                     (rt_done || (!busy_q && !rt_start && (!oval_q || ft_take)));
        pop        = std_rd || ft_load;
        rewind_occ = wrap_q ? CW'(DEPTH) : {1'b0, wptr_q};
    end

    // Write pointer and the record of whether it has wrapped since reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            wrap_q <= 1'b0;
        end else if (do_wr) begin
            wptr_q <= step(wptr_q);
            if (wptr_q == AW'(DEPTH - 1)) begin
                wrap_q <= 1'b1;
            end
        end
    end

    // Read pointer: rewound by retransmit, advanced by each pop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q <= '0;
        end else if (rt_start) begin
            rptr_q <= '0;
        end else if (pop) begin
            rptr_q <= step(rptr_q);
        end
    end

    // Occupancy, visible count and write-latency pipeline.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q   <= '0;
            vis_q   <= '0;
            wpipe_q <= '0;
        end else if (rt_start) begin
            occ_q   <= rewind_occ;
            vis_q   <= rewind_occ;
            wpipe_q <= '0;
        end else begin
            occ_q   <= occ_q + CW'(do_wr) - CW'(pop);
            vis_q   <= vis_q + CW'(wpipe_q[1]) - CW'(pop);
            wpipe_q <= {wpipe_q[0], do_wr};
        end
    end

    // Retransmit setup state and output-word validity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            oval_q <= 1'b0;
        end else begin
            if (rt_start) begin
                busy_q <= 1'b1;
            end else if (rt_done) begin
                busy_q <= 1'b0;
            end
            if (rt_start) begin
                oval_q <= 1'b0;
            end else if (ft_load) begin
                oval_q <= 1'b1;
            end else if (ft_take) begin
                oval_q <= 1'b0;
            end
        end
    end

    assign we        = do_wr;
    assign waddr     = wptr_q;
    assign raddr     = rptr_q;
    assign out_valid = oval_q;
    assign vis_nz    = (vis_q != '0);
    assign rt_busy   = busy_q;
    assign occ       = occ_q;
endmodule

// File: rtl/dmf_flagmap.sv
// Maps the internal state onto the two active-low status pins for the
// selected mode.
// Assumes: is_ft is stable outside master reset.
module dmf_flagmap (
    input  logic is_ft,
    input  logic vis_nz,
    input  logic rt_busy,
    input  logic out_valid,
    input  logic full,
    output logic rd_flag_n,
    output logic wr_flag_n
);
    // Standard mode uses empty/full; fall-through mode uses ready/ready.
    always_comb begin
        if (is_ft) begin
            rd_flag_n = !out_valid;
            wr_flag_n = full;
        end else begin
            rd_flag_n = vis_nz && !rt_busy;
            wr_flag_n = !full;
        end
    end
endmodule

// File: rtl/dual_mode_fifo.sv
// Dual-mode single-clock FIFO with retransmit.
// The mode is captured while master reset is low. Partial reset clears the
// pointers, flags and output but keeps the mode.
// Assumes: the clock runs during master reset, and a rewind request arrives
// only with both enables inactive.
module dual_mode_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = dmf_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             mode_sel,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en_n,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rewind_n,
    output logic             rd_flag_n,
    output logic             wr_flag_n
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    dmf_pkg::fifo_mode_e mode_q;
    logic                rst_all_n;
    logic                is_ft;
    logic                we, pop, out_valid, vis_nz, full, rt_busy;
    logic [AW-1:0]       waddr, raddr;
    logic [CW-1:0]       occ;
    logic [WIDTH-1:0]    ram_rdata;
    logic [WIDTH-1:0]    rd_q;

    assign rst_all_n = mrst_n & prst_n;
    assign is_ft     = (mode_q == dmf_pkg::MODE_FT);

    // Capture the mode input on every edge while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= dmf_pkg::fifo_mode_e'(mode_sel);
        end
    end

    dmf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (ram_rdata)
    );

    dmf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_all_n),
        .mode      (mode_q),
        .wr_en_n   (wr_en_n),
        .rd_en_n   (rd_en_n),
        .rewind_n  (rewind_n),
        .we        (we),
        .waddr     (waddr),
        .raddr     (raddr),
        .pop       (pop),
        .out_valid (out_valid),
        .vis_nz    (vis_nz),
        .full      (full),
        .rt_busy   (rt_busy),
        .occ       (occ)
    );

    dmf_flagmap u_flags (
        .is_ft     (is_ft),
        .vis_nz    (vis_nz),
        .rt_busy   (rt_busy),
        .out_valid (out_valid),
        .full      (full),
        .rd_flag_n (rd_flag_n),
        .wr_flag_n (wr_flag_n)
    );

    // Output register: cleared by either reset, loaded on each pop.
    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            rd_q <= '0;
        end else if (pop) begin
            rd_q <= ram_rdata;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/dmf_checker.sv
// Temporal checks for the dual-mode FIFO, bound into the top module.
// Assumes: a partial reset spans a clock edge, and a rewind request comes
// only with both enables high.
module dmf_checker #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 18,
    parameter int CW    = 5,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             is_ft,
    input logic             wr_en_n,
    input logic             rd_en_n,
    input logic             rewind_n,
    input logic             rd_flag_n,
    input logic [WIDTH-1:0] rd_data,
    input logic [CW-1:0]    occ,
    input logic [AW-1:0]    waddr,
    input logic             vis_nz,
    input logic             rt_busy
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R7

    AST_WR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_n |=> $stable(waddr)); // R4

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ft && !rd_flag_n) |=> $stable(rd_data)); // R8

    AST_FT_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ft && !rd_flag_n && rd_en_n) |=> $stable(rd_data)); // R6

    AST_RT_SETUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!rewind_n && wr_en_n && rd_en_n) |=> (is_ft ? rd_flag_n : !rd_flag_n)); // R9

    AST_RT_DONE_FT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ft && rt_busy && rewind_n && vis_nz) |=> !rd_flag_n); // R10
endmodule

bind dual_mode_fifo dmf_checker #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .CW    (CW),
    .AW    (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_all_n),
    .is_ft     (is_ft),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .rewind_n  (rewind_n),
    .rd_flag_n (rd_flag_n),
    .rd_data   (rd_data),
    .occ       (occ),
    .waddr     (waddr),
    .vis_nz    (vis_nz),
    .rt_busy   (rt_busy)
);

// File: tb/sim_dual_mode_fifo.sv
`timescale 1ns/1ps
module sim_dual_mode_fifo;
    localparam int DEPTH = 16;
    localparam logic [17:0] A1 = 18'h001A5;
    localparam logic [17:0] A2 = 18'h3C3C3;
    localparam logic [17:0] W0 = 18'h2D00F;
    localparam logic [17:0] B0 = 18'h0BEEF;
    localparam logic [17:0] B1 = 18'h15A5A;
    localparam logic [17:0] X0 = 18'h07777;

    // Table layout: [39] wr_en_n, [38] rd_en_n, [37:20] wr_data,
    //               [19] expected rd_flag_n, [18] expected wr_flag_n,
    //               [17:0] expected rd_data (standard mode).
    localparam logic [39:0] VEC [9] = '{
        {1'b0, 1'b1, A1,        1'b0, 1'b1, 18'h0},
        {1'b0, 1'b1, A2,        1'b0, 1'b1, 18'h0},
        {1'b1, 1'b1, 18'h0,     1'b1, 1'b1, 18'h0},
        {1'b1, 1'b0, 18'h0,     1'b1, 1'b1, A1},
        {1'b1, 1'b0, 18'h0,     1'b0, 1'b1, A2},
        {1'b1, 1'b0, 18'h0,     1'b0, 1'b1, A2},
        {1'b1, 1'b1, 18'h3FFFF, 1'b0, 1'b1, A2},
        {1'b1, 1'b1, 18'h2AAAA, 1'b0, 1'b1, A2},
        {1'b1, 1'b1, 18'h15555, 1'b0, 1'b1, A2}
    };

    logic        clk = 1'b0;
    logic        mrst_n, prst_n, mode_sel, wr_en_n, rd_en_n, rewind_n;
    logic [17:0] wr_data, rd_data;
    logic        rd_flag_n, wr_flag_n;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #2 clk = ~clk;

    dual_mode_fifo #(.DEPTH(DEPTH)) u0 (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .mode_sel  (mode_sel),
        .wr_en_n   (wr_en_n),
        .wr_data   (wr_data),
        .rd_en_n   (rd_en_n),
        .rd_data   (rd_data),
        .rewind_n  (rewind_n),
        .rd_flag_n (rd_flag_n),
        .wr_flag_n (wr_flag_n)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic t, input logic [17:0] d);
        wr_en_n  = w;
        rd_en_n  = r;
        rewind_n = t;
        wr_data  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic flags(input string req, input logic ea, input logic eb);
        chk(req, {17'b0, rd_flag_n}, {17'b0, ea});
        chk(req, {17'b0, wr_flag_n}, {17'b0, eb});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        mrst_n = 1'b0; prst_n = 1'b1; mode_sel = 1'b0;
        wr_en_n = 1'b1; rd_en_n = 1'b1; rewind_n = 1'b1; wr_data = '0;
        repeat (3) @(posedge clk);
        #1 mrst_n = 1'b1;
        chk("R1 reset data", rd_data, 18'h0);
        flags("R2 standard reset flags", 1'b0, 1'b1);

        // Table walk: standard-mode writes, reads, empty reads, idle writes (R4 R5 R8)
        for (int i = 0; i < 9; i++) begin
            cyc(VEC[i][39], VEC[i][38], 1'b1, VEC[i][37:20]);
            chk($sformatf("R5 row %0d rd_flag_n", i), {17'b0, rd_flag_n}, {17'b0, VEC[i][19]});
            chk($sformatf("R4 row %0d wr_flag_n", i), {17'b0, wr_flag_n}, {17'b0, VEC[i][18]});
            chk($sformatf("R8 row %0d data", i), rd_data, VEC[i][17:0]);
        end

        // Standard retransmit (R9 R10)
        cyc(1, 1, 0, 0); chk("R9 std setup flag", {17'b0, rd_flag_n}, 18'h0);
        cyc(1, 1, 0, 0); chk("R9 std setup held", {17'b0, rd_flag_n}, 18'h0);
        cyc(1, 1, 1, 0); chk("R10 std done flag", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 0, 1, 0); chk("R10 std reread first", rd_data, A1);
        cyc(1, 0, 1, 0); chk("R10 std reread second", rd_data, A2);
        chk("R10 std empty again", {17'b0, rd_flag_n}, 18'h0);

        // Fill to full, overflow attempt, drain (R7 R5 R8)
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 1, 1, 18'h100 + 18'(i));
            chk("R7 full flag during fill", {17'b0, wr_flag_n}, (i == DEPTH - 1) ? 18'h0 : 18'h1);
        end
        cyc(0, 1, 1, 18'h3FFFF); chk("R7 write while full", {17'b0, wr_flag_n}, 18'h0);
        cyc(1, 1, 1, 0);
        cyc(1, 1, 1, 0);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1, 0, 1, 0);
            chk("R5 drain order", rd_data, 18'h100 + 18'(i));
        end
        flags("R7 drained flags", 1'b0, 1'b1);
        cyc(1, 0, 1, 0); chk("R8 read while empty", rd_data, 18'h10F);

        // Master reset into fall-through mode (R1 R2)
        mode_sel = 1'b1; mrst_n = 1'b0;
        #1 chk("R1 async clear", rd_data, 18'h0);
        @(posedge clk); @(posedge clk); #1 mrst_n = 1'b1; mode_sel = 1'b0;
        flags("R2 fall-through reset flags", 1'b1, 1'b0);

        // First word falls through after three edges (R6)
        cyc(0, 1, 1, W0); chk("R6 edge 0", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 1, 1, 0);  chk("R6 edge 1", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 1, 1, 0);  chk("R6 edge 2", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 1, 1, 0);  flags("R6 edge 3 flag", 1'b0, 1'b0);
        chk("R6 edge 3 data", rd_data, W0);
        cyc(1, 1, 1, 0);  chk("R6 word held", rd_data, W0);
        cyc(0, 1, 1, B0); chk("R6 held during write", rd_data, W0);
        cyc(0, 1, 1, B1);
        cyc(1, 1, 1, 0);
        cyc(1, 0, 1, 0);  chk("R6 next word", rd_data, B0);
        cyc(1, 0, 1, 0);  chk("R6 third word", rd_data, B1);
        cyc(1, 0, 1, 0);  chk("R6 output ready off", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 0, 1, 0);  chk("R8 read with no ready word", rd_data, B1);

        // Fall-through retransmit (R9 R10)
        cyc(1, 1, 0, 0); chk("R9 ft setup flag", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 1, 0, 0); chk("R9 ft setup held", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 1, 1, 0); chk("R10 ft done flag", {17'b0, rd_flag_n}, 18'h0);
        chk("R10 ft location 0 on output", rd_data, W0);
        cyc(1, 0, 1, 0); chk("R10 ft continues", rd_data, B0);
        cyc(1, 0, 1, 0); chk("R10 ft continues 2", rd_data, B1);
        cyc(1, 0, 1, 0); chk("R10 ft end", {17'b0, rd_flag_n}, 18'h1);

        // Partial reset keeps fall-through mode (R3)
        prst_n = 1'b0;
        #1 chk("R3 async clear", rd_data, 18'h0);
        flags("R3 flags", 1'b1, 1'b0);
        @(posedge clk); #1 prst_n = 1'b1;
        cyc(0, 1, 1, X0); chk("R3 edge 0", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 1, 1, 0);
        cyc(1, 1, 1, 0);  chk("R3 edge 2", {17'b0, rd_flag_n}, 18'h1);
        cyc(1, 1, 1, 0);  chk("R3 mode kept data", rd_data, X0);
        chk("R3 mode kept flag", {17'b0, rd_flag_n}, 18'h0);

        // Master reset back to standard mode (R1 R2)
        mrst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1 mrst_n = 1'b1;
        flags("R2 standard again", 1'b0, 1'b1);
        chk("R1 data cleared", rd_data, 18'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule